// File: doc/BRIEF.md
# Shadowed Clock-Multiplier Control Registers

This block is a small register bank on a simple synchronous bus. It holds the settings that drive a clock multiplier: an enable, a connect select, a multiplier value and a divider value. Software writes new settings into holding registers. Those writes do not reach the multiplier. The values move into the shadow registers that drive the output pins only when software performs a two-write unlock sequence on a dedicated feed register.

A status register reads back the live shadow state together with a synchronized copy of the lock indication from the clock generator. Software can therefore tell what the multiplier is actually running with, even when the holding registers hold newer, uncommitted values. The connect output is qualified by lock. The system clock is never switched onto a multiplier that has not locked, whatever the shadow connect bit says.

Top module: `clkbank_top`

## Requirements
- R1: Registers are decoded at byte offsets 0x0 (control), 0x4 (configuration), 0x8 (status) and 0xC (feed) of a 4-bit address. Writes to any other address change nothing, and reads of any other address return 0.
- R2: Control and configuration writes land in holding registers that read back at once. They do not change pllEnable, pllConnect, pllMult or pllDiv.
- R3: A write of 32'h000000AA to the feed offset, followed by a write of 32'h00000055 to the feed offset as the next bus access, copies both holding registers into the shadow registers at that second write's clock edge. Idle cycles with no access between the two writes are allowed.
- R4: Any other access between the two feed writes cancels the sequence, and so does any other write value. This includes a read of any register, a write to any address, or a feed write of another value. A feed write of 32'h000000AA always starts a new sequence.
- R5: Status is read-only and reports the following. Bits 14:0 hold the shadow multiplier and bits 23:16 the shadow divider. Bit 24 is the shadow enable, bit 25 the shadow connect and bit 26 the synchronized lock. All other bits read 0.
- R6: pllConnect is high only when shadow enable, shadow connect and the lock input are all set. The lock input passes through a two-stage synchronizer before use.
- R7: Control uses bit 0 for enable and bit 1 for connect. Configuration uses bits 14:0 for the multiplier and bits 23:16 for the divider. Writes to all other bits are dropped, those bits read 0, and feed reads return 0.
- R8: After reset, all holding and shadow values and all outputs are 0, and no feed sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 4 | Byte address of the access |
| busWrite | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRead | input | 1 | Read strobe |
| busRdata | output | 32 | Read data, combinational during busRead, else 0 |
| pllLockIn | input | 1 | Asynchronous lock indication from the multiplier |
| pllEnable | output | 1 | Shadow enable |
| pllConnect | output | 1 | Lock-qualified connect select |
| pllMult | output | 15 | Shadow multiplier value |
| pllDiv | output | 8 | Shadow divider value |

## Verification
The hardest case to reach from the ports is an unlock sequence that is broken by a single interposed access. The access may be a status read, a holding write in the gap, a wrong feed value, or a repeated first key. It must then be shown that the shadow state neither moved nor was corrupted. The bench sweeps a recurring set of interposer kinds across many holding-register patterns. It tracks the expected holding, shadow and armed state in its own model, and after each attempt it compares the outputs and the status and holding read-back. The lock path is swept over all enable, connect and lock combinations after the synchronizer latency.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;
  localparam int DATA_W = 32;
  localparam int MUL_W  = 15;
  localparam int DIV_W  = 8;
  localparam int DIV_LSB = 16;
  localparam int EN_BIT   = 24;
  localparam int CONN_BIT = 25;
  localparam int LOCK_BIT = 26;
  localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h0000_00AA;
  localparam logic [DATA_W-1:0] KEY_SECOND = 32'h0000_0055;

  typedef struct packed {
    logic wrCtrl;
    logic wrCfg;
    logic commit;
    logic rdCtrl;
    logic rdCfg;
    logic rdStat;
  } bankStrobes_t;
endpackage

// File: rtl/clkbank_ctrl.sv
module clkbank_ctrl
  import clkbank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRead,
  output bankStrobes_t      strobes
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] OFS_FEED = ADDR_W'(4'hC);

  logic armed;
  logic anyAccess;
  logic feedWrite;
  logic keyOne;
  logic keyTwo;

  assign anyAccess = busWrite | busRead;
  assign feedWrite = busWrite && (busAddr == OFS_FEED);
  assign keyOne    = feedWrite && (busWdata == KEY_FIRST);
  assign keyTwo    = feedWrite && (busWdata == KEY_SECOND);

  always_comb begin
    strobes        = '0;
    strobes.wrCtrl = busWrite && (busAddr == OFS_CTRL);
    strobes.wrCfg  = busWrite && (busAddr == OFS_CFG);
    strobes.commit = armed && keyTwo && !busRead;
    strobes.rdCtrl = busRead && (busAddr == OFS_CTRL);
    strobes.rdCfg  = busRead && (busAddr == OFS_CFG);
    strobes.rdStat = busRead && (busAddr == OFS_STAT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (anyAccess) begin
      armed <= keyOne && !busRead;
    end
  end

  AST_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrCtrl, strobes.wrCfg, strobes.commit})); // R1
  AST_READ_CANCELS: assert property (@(posedge clk) disable iff (!rstN)
    busRead |=> !strobes.commit); // R4
  AST_COMMIT_AFTER_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (anyAccess && !keyOne) |=> !strobes.commit); // R4
endmodule

// File: rtl/clkbank_data.sv
module clkbank_data
  import clkbank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobes_t      strobes,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              pllLockIn,
  output logic [DATA_W-1:0] busRdata,
  output logic              pllEnable,
  output logic              pllConnect,
  output logic [MUL_W-1:0]  pllMult,
  output logic [DIV_W-1:0]  pllDiv
);
  localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

  logic             holdEn, holdConn, shEn, shConn;
  logic [MUL_W-1:0] holdMul, shMul;
  logic [DIV_W-1:0] holdDiv, shDiv;
  logic [SYNC_STAGES-1:0] lockPipe;
  logic             lockSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdEn   <= 1'b0;
      holdConn <= 1'b0;
      holdMul  <= '0;
      holdDiv  <= '0;
    end else begin
      if (strobes.wrCtrl) begin
        holdEn   <= busWdata[0];
        holdConn <= busWdata[1];
      end
      if (strobes.wrCfg) begin
        holdMul <= busWdata[MUL_W-1:0];
        holdDiv <= busWdata[DIV_MSB:DIV_LSB];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shEn   <= 1'b0;
      shConn <= 1'b0;
      shMul  <= '0;
      shDiv  <= '0;
    end else if (strobes.commit) begin
      shEn   <= holdEn;
      shConn <= holdConn;
      shMul  <= holdMul;
      shDiv  <= holdDiv;
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) lockPipe <= '0;
        else       lockPipe <= pllLockIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) lockPipe <= '0;
        else       lockPipe <= {lockPipe[SYNC_STAGES-2:0], pllLockIn};
      end
    end
  endgenerate
  assign lockSync = lockPipe[SYNC_STAGES-1];

  assign pllEnable  = shEn;
  assign pllConnect = shEn & shConn & lockSync;
  assign pllMult    = shMul;
  assign pllDiv     = shDiv;

  always_comb begin
    busRdata = '0;
    if (strobes.rdCtrl) begin
      busRdata[0] = holdEn;
      busRdata[1] = holdConn;
    end
    if (strobes.rdCfg) begin
      busRdata[MUL_W-1:0]      = holdMul;
      busRdata[DIV_MSB:DIV_LSB] = holdDiv;
    end
    if (strobes.rdStat) begin
      busRdata[MUL_W-1:0]      = shMul;
      busRdata[DIV_MSB:DIV_LSB] = shDiv;
      busRdata[EN_BIT]         = shEn;
      busRdata[CONN_BIT]       = shConn;
      busRdata[LOCK_BIT]       = lockSync;
    end
  end

  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable({shEn, shConn, shMul, shDiv})); // R2
  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> (pllMult == $past(holdMul)) && (pllDiv == $past(holdDiv))); // R3
endmodule

// File: rtl/clkbank_top.sv
module clkbank_top
  import clkbank_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRead,
  output logic [DATA_W-1:0] busRdata,
  input  logic              pllLockIn,
  output logic              pllEnable,
  output logic              pllConnect,
  output logic [MUL_W-1:0]  pllMult,
  output logic [DIV_W-1:0]  pllDiv
);
  bankStrobes_t strobes;

  clkbank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRead(busRead), .strobes(strobes)
  );

  clkbank_data #(.SYNC_STAGES(SYNC_STAGES)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
    .pllLockIn(pllLockIn), .busRdata(busRdata), .pllEnable(pllEnable),
    .pllConnect(pllConnect), .pllMult(pllMult), .pllDiv(pllDiv)
  );

  AST_CONNECT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    pllConnect |-> pllEnable); // R6
  AST_STATUS_TRACKS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == 4'h8) |-> (busRdata[EN_BIT] == pllEnable)); // R5
  AST_STATUS_TRACKS_MULT: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == 4'h8) |-> (busRdata[MUL_W-1:0] == pllMult)); // R5
endmodule

// File: tb/clkbank_top_bench.sv
`timescale 1ns/1ps
module clkbank_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRead = 1'b0;
  logic [31:0] busRdata;
  logic        pllLockIn = 1'b0;
  logic        pllEnable, pllConnect;
  logic [14:0] pllMult;
  logic [7:0]  pllDiv;

  int nChecks = 0;
  int nFails  = 0;

  logic [1:0]  mHoldCtrl = '0, mShCtrl = '0;
  logic [31:0] mHoldCfg = '0, mShCfg = '0;
  logic        mArmed = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #2 clk = ~clk;

  clkbank_top u_clkbank_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRead(busRead), .busRdata(busRdata),
    .pllLockIn(pllLockIn), .pllEnable(pllEnable), .pllConnect(pllConnect),
    .pllMult(pllMult), .pllDiv(pllDiv)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic modelAccess(input bit isWr, input logic [3:0] a, input logic [31:0] d);
    bit commitNow;
    commitNow = isWr && a == 4'hC && d == 32'h55 && mArmed;
    if (commitNow) begin
      mShCtrl = mHoldCtrl;
      mShCfg  = mHoldCfg;
    end
    mArmed = isWr && a == 4'hC && d == 32'hAA;
    if (isWr && a == 4'h0) mHoldCtrl = d[1:0];
    if (isWr && a == 4'h4) mHoldCfg = d & 32'h00FF_7FFF;
  endtask

  task automatic busWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(posedge clk);
    #1;
    busWrite = 1'b0;
    modelAccess(1'b1, a, d);
  endtask

  task automatic busRd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRead = 1'b1;
    #1;
    d = busRdata;
    @(posedge clk);
    #1;
    busRead = 1'b0;
    modelAccess(1'b0, a, 32'h0);
  endtask

  function automatic logic [31:0] expStatus();
    logic [31:0] s;
    s = mShCfg & 32'h00FF_7FFF;
    s[24] = mShCtrl[0];
    s[25] = mShCtrl[1];
    s[26] = pllLockIn;
    return s;
  endfunction

  task automatic checkOutputs(input string tag);
    logic [31:0] act, exp;
    act = {8'h0, pllDiv, 1'b0, pllMult};
    exp = mShCfg & 32'h00FF_7FFF;
    check(act == exp, tag, act, exp);
    check(pllEnable == mShCtrl[0], tag, {31'h0, pllEnable}, {31'h0, mShCtrl[0]});
    check(pllConnect == (mShCtrl[0] & mShCtrl[1] & pllLockIn), tag,
          {31'h0, pllConnect}, {31'h0, mShCtrl[0] & mShCtrl[1] & pllLockIn});
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R8: reset state
    checkOutputs("R8 reset outputs");
    busRd(4'h0, rd); check(rd == 0, "R8 ctrl reset", rd, 0);
    busRd(4'h4, rd); check(rd == 0, "R8 cfg reset", rd, 0);
    busRd(4'h8, rd); check(rd == 0, "R8 status reset", rd, 0);
    // R8: no sequence armed after reset, a lone second key does nothing
    busWr(4'h0, 32'h3); busWr(4'hC, 32'h55);
    checkOutputs("R8 no armed after reset");

    // R1 / R7: undecoded addresses and feed reads
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4 && a != 8 && a != 12) begin
        busWr(4'(a), 32'hFFFF_FFFF);
        busRd(4'(a), rd);
        check(rd == 0, "R1 undecoded read", rd, 0);
      end
    end
    busRd(4'h0, rd); check(rd == {30'h0, mHoldCtrl}, "R1 ctrl untouched", rd, {30'h0, mHoldCtrl});
    busRd(4'hC, rd); check(rd == 0, "R7 feed read", rd, 0);

    // R7 / R2: field sweep of the configuration holding register
    for (int b = 0; b < 32; b++) begin
      busWr(4'h4, 32'h1 << b);
      busRd(4'h4, rd);
      check(rd == ((32'h1 << b) & 32'h00FF_7FFF), "R7 cfg bit mask", rd, (32'h1 << b) & 32'h00FF_7FFF);
      checkOutputs("R2 holding no effect");
    end
    for (int b = 0; b < 32; b++) begin
      busWr(4'h0, 32'h1 << b);
      busRd(4'h0, rd);
      check(rd == ((32'h1 << b) & 32'h3), "R7 ctrl bit mask", rd, (32'h1 << b) & 32'h3);
    end

    // R3 / R4 / R5: unlock sequences with interposers
    for (int it = 0; it < 60; it++) begin
      lfsr = nextRand(nextRand(lfsr));
      busWr(4'h0, lfsr);
      lfsr = nextRand(nextRand(lfsr));
      busWr(4'h4, lfsr);
      busWr(4'hC, 32'hAA);
      case (it % 7)
        0: ;
        1: busRd(4'h8, rd);                        // R4 read cancels
        2: busWr(4'h0, ~lfsr);                     // R4 holding write cancels
        3: busWr(4'hC, 32'h12);                    // R4 wrong key
        4: busWr(4'hC, 32'hAA);                    // R4 restart
        5: repeat (3) @(posedge clk);              // R3 idle allowed
        default: busWr(4'hC, 32'h0000_01AA);       // R4 upper bits matter
      endcase
      busWr(4'hC, 32'h55);
      checkOutputs("R3/R4 feed sequence");
      busRd(4'h8, rd);
      check(rd == expStatus(), "R5 status layout", rd, expStatus());
      busRd(4'h4, rd);
      check(rd == mHoldCfg, "R2 cfg readback", rd, mHoldCfg);
    end

    // R6: lock qualification over all enable/connect/lock combinations
    for (int c = 0; c < 8; c++) begin
      busWr(4'h0, 32'(c & 3));
      busWr(4'hC, 32'hAA);
      busWr(4'hC, 32'h55);
      @(negedge clk);
      pllLockIn = c[2];
      repeat (3) @(posedge clk);
      #1;
      checkOutputs("R6 connect gating");
      busRd(4'h8, rd);
      check(rd == expStatus(), "R6 lock in status", rd, expStatus());
    end
    // R6: synchronizer latency, lock seen on the second edge
    busWr(4'h0, 32'h3); busWr(4'hC, 32'hAA); busWr(4'hC, 32'h55);
    @(negedge clk); pllLockIn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); pllLockIn = 1'b1;
    @(posedge clk); #1;
    check(pllConnect == 1'b0, "R6 sync stage one", {31'h0, pllConnect}, 0);
    @(posedge clk); #1;
    check(pllConnect == 1'b1, "R6 sync stage two", {31'h0, pllConnect}, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule